// File: doc/BRIEF.md
# Byte-Wide Programmable Memory Pin-Mode Emulator

This block is a synthesizable stand-in for a byte-wide, erasable, write-once-per-bit memory, seen from its control pins. One clock samples the active-low chip select, output select and program strobe. Two indicator inputs are sampled with them: one reports a high programming voltage, and the other reports a high voltage on address line 9. From these the block picks one of seven modes. The modes are read, output disabled, standby, program, program verify, program inhibit and identifier read. The data output and its enable follow the mode at once, with no register in the path.

The storage starts with every bit at one. Programming can only clear bits, because each write stores the bitwise AND of the old byte and the input byte. A write happens once for each falling edge of the program strobe that is seen in program mode. Holding the strobe low does not write again.

An erase pulse models ultraviolet exposure. It sweeps the whole array back to FFh, one address per clock, and holds a busy flag for the length of the sweep. The array depth is set by the address-width parameter, which is at least 10.

Top module: `eprom_emu`

## Requirements
- R1: After reset every location holds FFh, `busy` is 0, and with `ce_n` high `dout_en` is 0.
- R2: Read mode is entered with `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `pgm_n`=1. In read mode `dout_en` is 1 and `dout` equals the stored byte at `addr`.
- R3: With `ce_n`=1, `dout_en` is 0 and `dout` is 00h whatever `oe_n` is.
- R4: With `ce_n`=0 and `oe_n`=1, outside program mode, `dout_en` is 0 and `dout` is 00h.
- R5: Program mode is entered with `ce_n`=0, `pgm_n`=0 and `vpp_hi`=1; `oe_n` does not matter. In program mode `dout_en` is 0. A write stores old byte AND `din` at `addr`.
- R6: A write happens only on the first clock at which `pgm_n` is sampled 0 after being sampled 1 in program mode. Holding `pgm_n` low, or moving `addr` or `din` while it stays low, writes nothing more.
- R7: With `ce_n`=1 and `vpp_hi`=1, no write occurs on a `pgm_n` fall, and `dout_en` is 0.
- R8: Program verify is entered with `ce_n`=0, `oe_n`=0, `pgm_n`=1 and `vpp_hi`=1. It drives the stored byte at `addr` with `dout_en`=1.
- R9: Identifier read is entered with `ce_n`, `oe_n` and `pgm_n` all 0, `vpp_hi`=0 and `a9_hv`=1. It returns 01h when `addr[0]`=0 and 15h when `addr[0]`=1. Both values have odd parity across all 8 bits, with bit 7 as the parity bit. The level of `addr[9]` is ignored.
- R10: If any address bit other than bits 0 and 9 is 1, or if `pgm_n`=1, the identifier conditions give the stored byte at `addr` instead of an identifier.
- R11: An `erase` pulse seen while not busy raises `busy` on the next clock. `busy` then stays high for exactly 2^ADDR_W clocks, and afterwards every location reads FFh. While `busy` is high, `dout_en` is 0, program strobes are ignored, and further `erase` pulses do not restart the sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output select, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming voltage present |
| a9_hv | input | 1 | High voltage present on address line 9 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| erase | input | 1 | Erase request; sweeps all locations to FFh |
| dout | output | 8 | Output byte, 00h when not driven |
| dout_en | output | 1 | Output drive enable |
| busy | output | 1 | Erase sweep in progress |

## Verification
The bench programs the same location twice to show that bits only clear. A design that overwrote the byte instead of ANDing it would read back the second byte. It holds the strobe low while changing data and address, and it lowers the strobe while deselected and then selects the device. A level-triggered write would corrupt the stored byte in both cases.

Identifier read is tried with address line 9 driven both ways and with a stray upper address bit set. A decoder that checked line 9 would lose the identifier, and one that ignored the other address bits would give an identifier where stored data belongs. A second erase pulse in the middle of the sweep catches a sequencer that restarts, because the busy period would then be longer than one pass of the array.

// File: rtl/eprom_emu_pkg.sv
package eprom_emu_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_OUTDIS,
    MD_PROGRAM,
    MD_VERIFY,
    MD_READ,
    MD_IDENT
  } mode_e;

  localparam byte_t MFR_CODE = 8'h01;
  localparam byte_t DEV_CODE = 8'h15;

  // programming can only pull bits low
  function automatic byte_t prog_merge(byte_t old_b, byte_t new_b);
    return old_b & new_b;
  endfunction

  function automatic byte_t ident_byte(logic sel);
    return sel ? DEV_CODE : MFR_CODE;
  endfunction

  function automatic logic parity_odd(byte_t b);
    return ^b;
  endfunction
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_emu_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  pgm_n,
  input  logic  vpp_hi,
  input  logic  a9_hv,
  input  logic  id_addr_ok,
  output mode_e mode
);
  always_comb begin
    if (ce_n)                     mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    else if (vpp_hi && !pgm_n)    mode = MD_PROGRAM;
    else if (oe_n)                mode = MD_OUTDIS;
    else if (vpp_hi)              mode = MD_VERIFY;
    else if (!pgm_n && a9_hv && id_addr_ok) mode = MD_IDENT;
    else                          mode = MD_READ;
  end
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
  import eprom_emu_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] prog_addr,
  input  byte_t             prog_data,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output byte_t             rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  byte_t mem [DEPTH];
  byte_t old_b;

  assign old_b   = mem[prog_addr];
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (clr_en) begin
      mem[clr_addr] <= '1;
    end else if (prog_en) begin
      mem[prog_addr] <= prog_merge(old_b, prog_data);
    end
  end

  // R5: a write only clears bits of the old byte
  p_and_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !clr_en) |=> mem[$past(prog_addr)] == ($past(old_b) & $past(prog_data)));

  // R11: a swept location reads erased on the next cycle
  p_clear_ff_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> mem[$past(clr_addr)] == 8'hFF);
endmodule

// File: rtl/eprom_erase_seq.sv
module eprom_erase_seq #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  output logic              busy,
  output logic [ADDR_W-1:0] sweep_addr
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      sweep_addr <= '0;
    end else if (!busy) begin
      busy       <= erase;
      sweep_addr <= '0;
    end else begin
      if (sweep_addr == LAST) busy <= 1'b0;
      sweep_addr <= sweep_addr + 1'b1;
    end
  end

  p_sweep_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && erase) |=> (busy && sweep_addr == '0));

  p_sweep_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sweep_addr == LAST) |=> !busy);

  p_sweep_walk_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sweep_addr != LAST) |=> (busy && sweep_addr == $past(sweep_addr) + 1'b1));
endmodule

// File: rtl/eprom_emu.sv
module eprom_emu
  import eprom_emu_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              erase,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] ID_MASK = ~(ADDR_W'(1) | (ADDR_W'(1) << 9));

  mode_e             mode;
  logic              id_addr_ok;
  logic              pgm_q;
  logic              prog_fire;
  logic [ADDR_W-1:0] sweep_addr;
  byte_t             rd_data;
  logic              drive;

  assign id_addr_ok = (addr & ID_MASK) == '0;

  eprom_mode_dec u_dec (
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .pgm_n     (pgm_n),
    .vpp_hi    (vpp_hi),
    .a9_hv     (a9_hv),
    .id_addr_ok(id_addr_ok),
    .mode      (mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_q <= 1'b1;
    else        pgm_q <= pgm_n;
  end

  assign prog_fire = (mode == MD_PROGRAM) && pgm_q && !busy;

  eprom_erase_seq #(.ADDR_W(ADDR_W)) u_erase (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase     (erase),
    .busy      (busy),
    .sweep_addr(sweep_addr)
  );

  eprom_cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_en  (prog_fire),
    .prog_addr(addr),
    .prog_data(din),
    .clr_en   (busy),
    .clr_addr (sweep_addr),
    .rd_addr  (addr),
    .rd_data  (rd_data)
  );

  assign drive   = !busy && (mode == MD_READ || mode == MD_VERIFY || mode == MD_IDENT);
  assign dout_en = drive;
  assign dout    = !drive ? 8'h00 :
                   (mode == MD_IDENT) ? ident_byte(addr[0]) : rd_data;

  p_standby_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dout_en && dout == 8'h00));

  p_outdis_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !(vpp_hi && !pgm_n)) |-> !dout_en);

  p_prog_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !pgm_n && vpp_hi) |-> !dout_en);

  p_one_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |=> !prog_fire);

  p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && vpp_hi) |-> !prog_fire);

  p_id_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && mode == MD_IDENT) |-> parity_odd(dout));

  p_busy_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!dout_en && !prog_fire));
endmodule

// File: tb/eprom_emu_tb_top.sv
module eprom_emu_tb_top;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = 8'h00;
  logic          erase = 1'b0;
  logic [7:0]    dout;
  logic          dout_en;
  logic          busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      req;
    logic       en;
    logic [7:0] d;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  logic [7:0] mem_m [DEPTH];

  always #4 clk = ~clk;

  eprom_emu #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .din(din), .erase(erase),
    .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  // monitor: drains the expectation queue against live outputs
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() != 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (dout_en !== it.en || dout !== it.d) begin
          errors++;
          $display("FAIL %s: dout_en=%0b dout=%02h expected dout_en=%0b dout=%02h",
                   it.req, dout_en, dout, it.en, it.d);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic pins(input logic c, input logic o, input logic p, input logic v,
                      input logic h, input logic [AW-1:0] a, input logic [7:0] d);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a9_hv = h; addr = a; din = d;
  endtask

  task automatic expect_out(input string req, input logic en, input logic [7:0] d);
    exp_t it;
    #1;
    it.req = req; it.en = en; it.d = d;
    exp_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic flag_chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [AW-1:0] a);
    pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 8'h00);
    expect_out(req, 1'b1, mem_m[a]);
  endtask

  task automatic prog_byte(input logic [AW-1:0] a, input logic [7:0] d);
    pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, a, d);
    tick();
    pins(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, a, d);
    expect_out("R5 program mode output off", 1'b0, 8'h00);
    tick();
    mem_m[a] = mem_m[a] & d;
    pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, a, d);
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    flag_chk("R1 busy after reset", busy, 1'b0);
    expect_out("R1 deselected after reset", 1'b0, 8'h00);
    read_chk("R1 erased byte", 11'd5);
    read_chk("R2 read erased top", 11'h7FF);

    // R5 AND programming
    prog_byte(11'd5, 8'hA5);
    read_chk("R5 first write", 11'd5);
    prog_byte(11'd5, 8'h3C);
    read_chk("R5 second write ANDed", 11'd5);
    prog_byte(11'd0, 8'h77);
    prog_byte(11'd8, 8'h5A);
    prog_byte(11'h400, 8'hC3);
    read_chk("R2 read addr 0", 11'd0);
    read_chk("R2 read addr 400h", 11'h400);

    // R6 one write per strobe fall
    pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 11'd20, 8'hF0);
    tick();
    pgm_n = 1'b0;
    tick();
    mem_m[20] = mem_m[20] & 8'hF0;
    din = 8'h00;
    tick(); tick(); tick();
    addr = 11'd21;
    tick();
    pgm_n = 1'b1;
    tick();
    read_chk("R6 held strobe no rewrite", 11'd20);
    read_chk("R6 moved address no write", 11'd21);
    prog_byte(11'd20, 8'h0F);
    read_chk("R6 new fall writes", 11'd20);

    // R7 inhibit
    pins(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 11'd30, 8'h00);
    tick();
    pgm_n = 1'b0;
    expect_out("R7 inhibit output off", 1'b0, 8'h00);
    tick(); tick();
    ce_n = 1'b0;
    tick();
    pgm_n = 1'b1;
    tick();
    read_chk("R7 inhibited location untouched", 11'd30);

    // R8 verify
    pins(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'd5, 8'h00);
    expect_out("R8 verify shows byte", 1'b1, mem_m[5]);

    // R9 identifier
    pins(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 11'h000, 8'h00);
    expect_out("R9 maker code", 1'b1, 8'h01);
    addr = 11'h001;
    expect_out("R9 device code", 1'b1, 8'h15);
    addr = 11'h201;
    expect_out("R9 addr9 ignored", 1'b1, 8'h15);
    addr = 11'h200;
    expect_out("R9 addr9 ignored maker", 1'b1, 8'h01);

    // R10 identifier qualifier
    addr = 11'h008;
    expect_out("R10 stray bit gives array", 1'b1, mem_m[8]);
    addr = 11'h400;
    expect_out("R10 top bit gives array", 1'b1, mem_m[11'h400]);
    pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 11'h000, 8'h00);
    expect_out("R10 strobe high gives array", 1'b1, mem_m[0]);

    // R3 standby
    pins(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'd5, 8'h00);
    expect_out("R3 standby oe low", 1'b0, 8'h00);
    oe_n = 1'b1;
    expect_out("R3 standby oe high", 1'b0, 8'h00);

    // R4 output disable
    pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd5, 8'h00);
    expect_out("R4 output disable", 1'b0, 8'h00);
    vpp_hi = 1'b1;
    expect_out("R4 verify with oe high", 1'b0, 8'h00);

    // R11 erase sweep
    pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd5, 8'h00);
    erase = 1'b1;
    tick();
    erase = 1'b0;
    flag_chk("R11 busy rises", busy, 1'b1);
    expect_out("R11 output off while busy", 1'b0, 8'h00);
    begin
      int n;
      n = 0;
      while (busy === 1'b1 && n < DEPTH + 50) begin
        n++;
        if (n == 100) erase = 1'b1;
        if (n == 101) erase = 1'b0;
        tick();
      end
      checks++;
      if (n != DEPTH) begin
        errors++;
        $display("FAIL R11 busy length: got %0d expected %0d", n, DEPTH);
      end
    end
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
    read_chk("R11 erased addr 5", 11'd5);
    read_chk("R11 erased addr 20", 11'd20);
    read_chk("R11 erased addr 400h", 11'h400);

    tick();
    finish_run();
  end
endmodule